// File: doc/BRIEF.md
# I/O MMU Failure-Mode Supervisor

This block watches for uncorrected errors found in the internal state of an I/O memory management unit and decides when the unit can no longer be trusted. An error reported as global means internal consistency is lost, or probably lost, and it moves the block into a failure mode. An error reported as confined to an isolated partition leaves the block where it is. Once the block is in failure mode, it stays there until reset.

While in failure mode, the block stops client traffic and queue activity, but not register access. New client requests are no longer forwarded to the translation engine. Each one is terminated with a locally generated abort response instead. Responses from the translation engine that are still in flight are rewritten to abort codes, so no partial translation result reaches a client. Every command, event and page-request queue grant is forced low. Register reads are always granted, so software can diagnose the failure.

On entry, the block raises the failure flag in both the non-secure and the secure error views. It pulses a recovery interrupt once and latches the cause of the first entry as a syndrome.

Top module: `fail_mode_supervisor`

## Requirements
- R1: A global error (`ue_valid`=1, `ue_isolated`=0) in normal mode sets `fail_mode`, `gerr_ns` and `gerr_s` to 1 at the next clock edge.
- R2: An error with `ue_isolated`=1 leaves `fail_mode`, `gerr_ns`, `gerr_s` and `rec_irq` at 0.
- R3: Once set, `fail_mode` stays set until `rst_n` is sampled low. No other input clears it.
- R4: A client request (`req_valid`) seen while in failure mode, or in the cycle a global error arrives, is not forwarded (`xl_fwd`=0). One cycle later it is answered with `blk_valid`=1 and `blk_code` set to 2'b11 (completer abort) if `req_pcie`=1, or to 2'b10 (abort) otherwise. In normal mode `xl_fwd` equals `req_valid` and `blk_valid` stays 0.
- R5: A translation engine response (`xl_valid`) in failure mode, or in the entry cycle, leaves with `rsp_code` 2'b11 if `xl_pcie`=1 and 2'b10 otherwise. In normal mode `rsp_code` equals `xl_code`, and `rsp_valid` always equals `xl_valid`.
- R6: In failure mode, and in the entry cycle, `q_gnt` is all zero. In normal mode `q_gnt` equals `q_req`.
- R7: `rd_gnt` equals `rd_req` in every mode.
- R8: `rec_irq` is high for exactly the one cycle after entry. It does not repeat for further errors while in failure mode.
- R9: `syndrome` captures `ue_cause` of the entry error and holds it against later errors until reset.
- R10: After reset, `fail_mode`, `gerr_ns`, `gerr_s`, `rec_irq`, `blk_valid` and `syndrome` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ue_valid | input | 1 | Uncorrected error detected in internal state |
| ue_isolated | input | 1 | Error confined to an isolated partition |
| ue_cause | input | CW | Cause code of the error |
| req_valid | input | 1 | New client translation request |
| req_pcie | input | 1 | Request is PCIe-style |
| xl_fwd | output | 1 | Request forwarded to translation engine |
| blk_valid | output | 1 | Locally terminated response valid |
| blk_code | output | 2 | Locally terminated response code |
| xl_valid | input | 1 | Translation engine response valid |
| xl_pcie | input | 1 | Engine response belongs to a PCIe-style request |
| xl_code | input | 2 | Engine response code |
| rsp_valid | output | 1 | Client response valid |
| rsp_code | output | 2 | Client response code |
| q_req | input | NQ | Queue engine access requests |
| q_gnt | output | NQ | Queue engine access grants |
| rd_req | input | 1 | Register read request |
| rd_gnt | output | 1 | Register read grant |
| fail_mode | output | 1 | Failure mode active |
| gerr_ns | output | 1 | Failure flag, non-secure error view |
| gerr_s | output | 1 | Failure flag, secure error view |
| rec_irq | output | 1 | Recovery interrupt pulse |
| syndrome | output | CW | Cause of the first entry |

## Verification
The assertions check on every cycle that:
- failure mode is sticky;
- an isolated error never causes entry;
- the interrupt is a lone pulse tied to the rise of the mode;
- queue grants are zero during the mode;
- engine responses carry abort codes during the mode;
- the syndrome is frozen while the mode holds.

Only the bench scenarios can show the rest:
- the entry cycle itself already blocks traffic;
- the exact abort codes follow the PCIe flag on both response paths;
- the first cause wins over a later one;
- register reads pass during the mode;
- reset returns the block to normal forwarding.

// File: rtl/fail_mode_supervisor.sv
module fail_mode_supervisor #(
  parameter int NQ = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ue_valid,
  input  logic          ue_isolated,
  input  logic [CW-1:0] ue_cause,
  input  logic          req_valid,
  input  logic          req_pcie,
  output logic          xl_fwd,
  output logic          blk_valid,
  output logic [1:0]    blk_code,
  input  logic          xl_valid,
  input  logic          xl_pcie,
  input  logic [1:0]    xl_code,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  input  logic [NQ-1:0] q_req,
  output logic [NQ-1:0] q_gnt,
  input  logic          rd_req,
  output logic          rd_gnt,
  output logic          fail_mode,
  output logic          gerr_ns,
  output logic          gerr_s,
  output logic          rec_irq,
  output logic [CW-1:0] syndrome
);
  localparam logic [1:0] CODE_ABT = 2'b10;
  localparam logic [1:0] CODE_CA  = 2'b11;

  logic          fail_q, irq_q, blk_v_q;
  logic [1:0]    blk_c_q;
  logic [CW-1:0] syn_q;

  wire entry    = ue_valid & ~ue_isolated;
  wire fail_now = fail_q | entry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      irq_q   <= 1'b0;
      syn_q   <= '0;
      blk_v_q <= 1'b0;
      blk_c_q <= 2'b00;
    end else begin
      irq_q   <= entry & ~fail_q;
      if (entry & ~fail_q) syn_q <= ue_cause;
      if (entry) fail_q <= 1'b1;
      blk_v_q <= req_valid & fail_now;
      blk_c_q <= req_pcie ? CODE_CA : CODE_ABT;
    end
  end

  assign xl_fwd    = req_valid & ~fail_now;
  assign blk_valid = blk_v_q;
  assign blk_code  = blk_v_q ? blk_c_q : 2'b00;
  assign rsp_valid = xl_valid;
  assign rsp_code  = fail_now ? (xl_pcie ? CODE_CA : CODE_ABT) : xl_code;
  assign q_gnt     = fail_now ? '0 : q_req;
  assign rd_gnt    = rd_req;
  assign fail_mode = fail_q;
  assign gerr_ns   = fail_q;
  assign gerr_s    = fail_q;
  assign rec_irq   = irq_q;
  assign syndrome  = syn_q;

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_mode |=> fail_mode);
  a_r2_isolated_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!fail_mode && ue_valid && ue_isolated) |=> !fail_mode);
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rec_irq |=> !rec_irq);
  a_r8_irq_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    rec_irq |-> (fail_mode && !$past(fail_mode)));
  a_r6_queues_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    fail_mode |-> (q_gnt == '0));
  a_r5_abort_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_mode && rsp_valid) |-> rsp_code[1]);
  a_r9_syndrome_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    fail_mode |=> $stable(syndrome));
endmodule

// File: tb/test_fail_mode_supervisor.sv
module test_fail_mode_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 3;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ue_valid = 0, ue_isolated = 0;
  logic [CW-1:0] ue_cause = '0;
  logic req_valid = 0, req_pcie = 0, xl_valid = 0, xl_pcie = 0, rd_req = 0;
  logic [1:0] xl_code = '0;
  logic [NQ-1:0] q_req = '0;
  logic xl_fwd, blk_valid, rsp_valid, rd_gnt, fail_mode, gerr_ns, gerr_s, rec_irq;
  logic [1:0] blk_code, rsp_code;
  logic [NQ-1:0] q_gnt;
  logic [CW-1:0] syndrome;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fail_mode_supervisor #(.NQ(NQ), .CW(CW)) i_fail_mode_supervisor (
    .clk(clk), .rst_n(rst_n), .ue_valid(ue_valid), .ue_isolated(ue_isolated),
    .ue_cause(ue_cause), .req_valid(req_valid), .req_pcie(req_pcie),
    .xl_fwd(xl_fwd), .blk_valid(blk_valid), .blk_code(blk_code),
    .xl_valid(xl_valid), .xl_pcie(xl_pcie), .xl_code(xl_code),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .q_req(q_req), .q_gnt(q_gnt),
    .rd_req(rd_req), .rd_gnt(rd_gnt), .fail_mode(fail_mode), .gerr_ns(gerr_ns),
    .gerr_s(gerr_s), .rec_irq(rec_irq), .syndrome(syndrome));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    ue_valid = 0; ue_isolated = 0; ue_cause = '0; req_valid = 0; req_pcie = 0;
    xl_valid = 0; xl_pcie = 0; xl_code = '0; q_req = '0; rd_req = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    next_cycle(); next_cycle();
    rst_n = 1;
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R10 fail_mode", fail_mode, 0);
    chk("R10 gerr_ns", gerr_ns, 0);
    chk("R10 gerr_s", gerr_s, 0);
    chk("R10 rec_irq", rec_irq, 0);
    chk("R10 blk_valid", blk_valid, 0);
    chk("R10 syndrome", syndrome, 0);
  endtask

  task automatic t_normal();
    req_valid = 1; xl_valid = 1; xl_code = 2'b01; q_req = 3'b101; rd_req = 1;
    #1;
    chk("R4 xl_fwd normal", xl_fwd, 1);
    chk("R5 rsp passthrough", rsp_code, 1);
    chk("R5 rsp_valid", rsp_valid, 1);
    chk("R6 q_gnt normal", q_gnt, 5);
    chk("R7 rd_gnt normal", rd_gnt, 1);
    next_cycle();
    chk("R4 blk_valid normal", blk_valid, 0);
    idle();
  endtask

  task automatic t_isolated();
    ue_valid = 1; ue_isolated = 1; ue_cause = 4'd5; q_req = 3'b111;
    #1;
    chk("R2 q_gnt isolated", q_gnt, 7);
    next_cycle();
    idle();
    chk("R2 fail_mode", fail_mode, 0);
    chk("R2 gerr_ns", gerr_ns, 0);
    chk("R2 gerr_s", gerr_s, 0);
    chk("R2 rec_irq", rec_irq, 0);
  endtask

  task automatic t_entry();
    ue_valid = 1; ue_cause = 4'd9; req_valid = 1; req_pcie = 0;
    xl_valid = 1; xl_pcie = 1; xl_code = 2'b00; q_req = 3'b111; rd_req = 1;
    #1;
    chk("R4 xl_fwd entry", xl_fwd, 0);
    chk("R5 inflight CA", rsp_code, 3);
    chk("R6 q_gnt entry", q_gnt, 0);
    chk("R7 rd_gnt entry", rd_gnt, 1);
    next_cycle();
    idle();
    chk("R1 fail_mode", fail_mode, 1);
    chk("R1 gerr_ns", gerr_ns, 1);
    chk("R1 gerr_s", gerr_s, 1);
    chk("R8 rec_irq pulse", rec_irq, 1);
    chk("R9 syndrome", syndrome, 9);
    chk("R4 blk_valid entry", blk_valid, 1);
    chk("R4 blk_code abort", blk_code, 2);
    next_cycle();
    chk("R8 rec_irq single", rec_irq, 0);
    chk("R4 blk_valid drop", blk_valid, 0);
  endtask

  task automatic t_in_mode();
    req_valid = 1; req_pcie = 1; xl_valid = 1; xl_pcie = 0; xl_code = 2'b01;
    q_req = 3'b010; rd_req = 1;
    #1;
    chk("R4 xl_fwd blocked", xl_fwd, 0);
    chk("R5 rsp abort", rsp_code, 2);
    chk("R6 q_gnt blocked", q_gnt, 0);
    chk("R7 rd_gnt in mode", rd_gnt, 1);
    next_cycle();
    idle();
    chk("R4 blk_valid pcie", blk_valid, 1);
    chk("R4 blk_code CA", blk_code, 3);
  endtask

  task automatic t_second_error();
    ue_valid = 1; ue_cause = 4'd3;
    next_cycle();
    idle();
    chk("R8 no repeat irq", rec_irq, 0);
    chk("R9 syndrome held", syndrome, 9);
    chk("R3 still failed", fail_mode, 1);
    for (int i = 0; i < 5; i++) next_cycle();
    chk("R3 sticky", fail_mode, 1);
  endtask

  task automatic t_reset_exit();
    do_reset();
    chk("R3 reset clears", fail_mode, 0);
    chk("R3 gerr cleared", gerr_ns, 0);
    chk("R10 syndrome cleared", syndrome, 0);
    req_valid = 1; q_req = 3'b011;
    #1;
    chk("R4 forward after reset", xl_fwd, 1);
    chk("R6 grant after reset", q_gnt, 3);
    idle();
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_normal();
        t_isolated();
        t_entry();
        t_in_mode();
        t_second_error();
        t_reset_exit();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule